// File: doc/BRIEF.md
# Serial Port Power-State Controller

This block decides the power state of a two-port isolated serial link used in a daisy-chain. It has three states. IDLE keeps the port drivers off. READY keeps them powered and able to communicate. ACTIVE means data is moving on at least one port.

A wakeup pulse detected on port A starts a wakeup delay. The length of that delay depends on whether the core is asleep or on standby. When the delay runs out, the controller enters READY.

Transmit or receive activity moves the controller from READY to ACTIVE. When the activity stops, it falls back to READY. If READY sees no wakeup and no activity for more than 5.5 ms, the controller drops back to IDLE.

A mode input selects between two variants. In the two-port chained variant both ports are enabled. In the single-port addressed variant port B stays off.

All delays are counted in pulses of a free-running `tick` input. The 5.5 ms limit is derived from the tick rate, given as a parameter.

Top module: `sport_power_ctrl`

## Requirements
- R1: During and after reset, `state` is IDLE, and `en_a`, `en_b` and `wake_pending` are 0. The state encoding is 2'd0 IDLE, 2'd1 READY, 2'd2 ACTIVE.
- R2: When `wake_a` is high in IDLE with `core_sleep`=0 and nothing is pending, `wake_pending` is 1 from the next cycle on. `state` becomes READY on the clock edge that samples the T_READY_TICKS-th `tick` pulse after that edge. A tick in the same cycle as the wakeup is not counted.
- R3: The same sequence with `core_sleep`=1 takes T_WAKE_TICKS tick pulses instead.
- R4: While a wakeup delay is pending, `act_tx`, `act_rx` and further `wake_a` pulses have no effect. The state stays IDLE and the delay neither lengthens nor shortens.
- R5: In READY, `act_tx` or `act_rx` high moves `state` to ACTIVE on the next edge.
- R6: In ACTIVE, a cycle with both activity flags low moves `state` to READY on the next edge, and the idle count restarts from zero.
- R7: READY returns to IDLE on the (TIMEOUT+1)-th consecutive tick with no wakeup and no activity, where TIMEOUT = TICK_HZ*11/2000 ticks (5.5 ms).
- R8: A `wake_a` pulse in READY restarts the idle count. This holds even when it coincides with the tick that would otherwise expire the timeout.
- R9: `en_a` is 1 exactly in READY and ACTIVE. `en_b` equals `en_a` when `daisy_mode`=1 and is 0 when `daisy_mode`=0.
- R10: Activity flags in IDLE with no wakeup pending leave the state IDLE and do not set `wake_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Free-running time-base pulse |
| wake_a | input | 1 | Wakeup pulse detected on port A |
| act_tx | input | 1 | Transmit activity on either port |
| act_rx | input | 1 | Receive activity on either port |
| core_sleep | input | 1 | 1: core asleep (long delay), 0: core on standby (short delay) |
| daisy_mode | input | 1 | 1: two-port chained variant, 0: single-port addressed variant |
| state | output | 2 | Current power state |
| en_a | output | 1 | Port A powered |
| en_b | output | 1 | Port B powered |
| wake_pending | output | 1 | Wakeup delay in progress |

## Verification
The interesting collision is a refreshing wakeup (or activity) in READY that lands in the same cycle as the tick that would expire the idle timeout. A directed case counts exactly TIMEOUT idle ticks and then drives `wake_a` and `tick` together. The state must stay READY, and a full fresh TIMEOUT window must follow before IDLE. Random phases drive ticks, wakeups and activity bursts densely enough that these and the pending-wakeup collisions recur. Every cycle is compared against a bench reference model of the requirements.

// File: rtl/sport_power_ctrl.sv
module sport_power_ctrl #(
  parameter int T_READY_TICKS = 8,
  parameter int T_WAKE_TICKS  = 200,
  parameter int TICK_HZ       = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wake_a,
  input  logic       act_tx,
  input  logic       act_rx,
  input  logic       core_sleep,
  input  logic       daisy_mode,
  output logic [1:0] state,
  output logic       en_a,
  output logic       en_b,
  output logic       wake_pending
);
  localparam int TIMEOUT = TICK_HZ * 11 / 2000;
  localparam int DLY_MAX = (T_WAKE_TICKS > T_READY_TICKS) ? T_WAKE_TICKS : T_READY_TICKS;
  localparam int DW = $clog2(DLY_MAX + 1);
  localparam int IW = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_READY = 2'd1, S_ACTIVE = 2'd2} st_t;

  st_t           st;
  logic          pend;
  logic [DW-1:0] dly;
  logic [IW-1:0] idle_cnt;
  wire           act = act_tx | act_rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      pend     <= 1'b0;
      dly      <= '0;
      idle_cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (pend) begin
            if (tick) begin
              if (dly <= DW'(1)) begin
                st       <= S_READY;
                pend     <= 1'b0;
                idle_cnt <= '0;
              end else begin
                dly <= dly - DW'(1);
              end
            end
          end else if (wake_a) begin
            pend <= 1'b1;
            dly  <= core_sleep ? DW'(T_WAKE_TICKS) : DW'(T_READY_TICKS);
          end
        end
        S_READY: begin
          if (act) begin
            st       <= S_ACTIVE;
            idle_cnt <= '0;
          end else if (wake_a) begin
            idle_cnt <= '0;
          end else if (tick) begin
            if (idle_cnt == IW'(TIMEOUT)) begin
              st       <= S_IDLE;
              idle_cnt <= '0;
            end else begin
              idle_cnt <= idle_cnt + IW'(1);
            end
          end
        end
        S_ACTIVE: begin
          idle_cnt <= '0;
          if (!act) st <= S_READY;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign state        = st;
  assign wake_pending = pend;
  assign en_a         = (st != S_IDLE);
  assign en_b         = en_a & daisy_mode;

  // R4: a pending delay only exists while the ports are off
  p_pend_in_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> st == S_IDLE);

  // R2/R3: READY is entered from IDLE only by a finishing delay on a tick
  p_ready_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READY && $past(st) == S_IDLE) |-> ($past(pend) && $past(tick)));

  // R10: a delay starts only from a wakeup pulse
  p_pend_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(wake_a));

  // R5: ACTIVE is held only while activity was seen
  p_active_needs_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_ACTIVE |-> $past(act_tx | act_rx));

  // R7/R8: the timeout exit needs a quiet tick in READY
  p_timeout_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) != S_IDLE) |->
      ($past(st) == S_READY && $past(tick) && !$past(wake_a) && !$past(act_tx | act_rx)));

  // R7: the idle counter never passes the limit
  p_idle_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= IW'(TIMEOUT));
endmodule

// File: tb/sport_power_ctrl_tb.sv
module sport_power_ctrl_tb;
  localparam int TR = 3;
  localparam int TW = 9;
  localparam int HZ = 4000;
  localparam int TO = HZ * 11 / 2000;

  logic clk = 0, rst_n = 0, tick = 0, wake_a = 0, act_tx = 0, act_rx = 0;
  logic core_sleep = 0, daisy_mode = 1;
  logic [1:0] state;
  logic en_a, en_b, wake_pending;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_st = 0, m_dly = 0, m_idle = 0;
  bit m_pend = 0;

  always #10 clk = ~clk;

  sport_power_ctrl #(.T_READY_TICKS(TR), .T_WAKE_TICKS(TW), .TICK_HZ(HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wake_a(wake_a), .act_tx(act_tx),
    .act_rx(act_rx), .core_sleep(core_sleep), .daisy_mode(daisy_mode),
    .state(state), .en_a(en_a), .en_b(en_b), .wake_pending(wake_pending));

  function automatic void model_step();
    bit act = act_tx | act_rx;
    if (!rst_n) begin
      m_st = 0; m_pend = 0; m_dly = 0; m_idle = 0;
    end else if (m_st == 0) begin
      if (m_pend) begin
        if (tick) begin
          if (m_dly <= 1) begin m_st = 1; m_pend = 0; m_idle = 0; end
          else m_dly--;
        end
      end else if (wake_a) begin
        m_pend = 1; m_dly = core_sleep ? TW : TR;
      end
    end else if (m_st == 1) begin
      if (act) begin m_st = 2; m_idle = 0; end
      else if (wake_a) m_idle = 0;
      else if (tick) begin
        if (m_idle == TO) begin m_st = 0; m_idle = 0; end
        else m_idle++;
      end
    end else begin
      m_idle = 0;
      if (!act) m_st = 1;
    end
  endfunction

  task automatic check(string tag);
    bit ea = (m_st != 0);
    bit eb = ea & daisy_mode;
    checks++;
    if (state !== m_st[1:0] || en_a !== ea || en_b !== eb || wake_pending !== m_pend) begin
      fails++;
      $display("FAIL %s: state=%0d en_a=%0b en_b=%0b pend=%0b expected state=%0d en_a=%0b en_b=%0b pend=%0b",
               tag, state, en_a, en_b, wake_pending, m_st, ea, eb, m_pend);
    end
  endtask

  task automatic cyc(bit t, bit w, bit tx, bit rx, string tag);
    tick = t; wake_a = w; act_tx = tx; act_rx = rx;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  task automatic expect_state(int s, string tag);
    checks++;
    if (state !== s[1:0]) begin
      fails++;
      $display("FAIL %s: state=%0d expected %0d", tag, state, s);
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    @(negedge clk);
    cyc(0, 0, 0, 0, "R1");
    cyc(1, 1, 1, 0, "R1");
    rst_n = 1;
    cyc(0, 0, 1, 1, "R10");
    expect_state(0, "R10");

    core_sleep = 0;
    cyc(1, 1, 0, 0, "R2");
    for (int i = 0; i < TR - 1; i++) cyc(1, 0, 0, 0, "R2");
    expect_state(0, "R2");
    cyc(1, 0, 0, 0, "R2");
    expect_state(1, "R2");

    cyc(0, 0, 1, 0, "R5");
    expect_state(2, "R5");
    cyc(1, 0, 0, 1, "R5");
    cyc(1, 0, 0, 0, "R6");
    expect_state(1, "R6");

    for (int i = 0; i < TO; i++) cyc(1, 0, 0, 0, "R7");
    cyc(1, 1, 0, 0, "R8");
    expect_state(1, "R8");
    for (int i = 0; i < TO; i++) cyc(1, 0, 0, 0, "R8");
    expect_state(1, "R8");
    cyc(1, 0, 0, 0, "R7");
    expect_state(0, "R7");

    core_sleep = 1; daisy_mode = 0;
    cyc(0, 1, 0, 0, "R3");
    for (int i = 0; i < TW - 1; i++) cyc(1, i % 2 == 0, i % 3 == 0, 1, "R4");
    expect_state(0, "R4");
    cyc(1, 0, 1, 0, "R3");
    expect_state(1, "R3");
    cyc(0, 0, 0, 0, "R9");
    daisy_mode = 1;
    cyc(0, 0, 0, 0, "R9");

    begin
      int burst = 0;
      for (int n = 0; n < 6000; n++) begin
        bit t, w, tx, rx;
        if (n % 700 == 0) daisy_mode = $urandom % 2;
        core_sleep = $urandom % 2;
        t = ($urandom % 2) == 0;
        w = ($urandom % 30) == 0;
        if (burst > 0) begin
          burst--; tx = $urandom % 2; rx = !tx | ($urandom % 2);
        end else begin
          tx = 0; rx = 0;
          if ($urandom % 40 == 0) burst = 1 + $urandom % 6;
        end
        cyc(t, w, tx, rx, "R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
      end
    end

    rst_n = 0;
    cyc(0, 0, 0, 0, "R1");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule